// File: doc/BRIEF.md
# Peripheral Control Word with Atomic Alias Writes

This block is the 32-bit control register that software uses to bring one peripheral out of reset and to open or close its clock. It sits on a simple write strobe with four word-addressed aliases. One alias overwrites the whole word. The other three change only the bits marked with 1 in the write data: they set those bits, clear them or invert them. Software can therefore change one control bit without a read-modify-write sequence.

The two top bits carry special meaning. Bit 31 is the soft-reset request and bit 30 is the clock-gate request. While soft-reset is 1, the block drives the peripheral reset output and keeps the 30 lower bits at zero. After soft-reset has been 1 for three cycles, hardware raises clock-gate by itself. Soft-reset takes three cycles to settle in either direction. During that window the block keeps the reset output active and keeps clock-gate forced on. The peripheral is usable only after software has cleared both bits and the window has passed. The clock-enable output is the inverse of clock-gate. It drives an external gating cell.

Top module: `ctl_alias_reg`

## Requirements
- R1: After the asynchronous reset, the read value is 0xC000_0000 (soft-reset bit 31 = 1, clock-gate bit 30 = 1, bits 29..0 = 0), the peripheral reset output is 1 and the clock enable is 0.
- R2: A write to word index 0 (byte offset 0x0) replaces the register with the write data on the next clock edge, subject to R6 and R7.
- R3: A write to word index 1 (offset 0x4) sets every bit that is 1 in the data and leaves the other bits unchanged. Bits 31 and 30 set this way always read 1 on the next cycle.
- R4: A write to word index 2 (offset 0x8) clears every bit that is 1 in the data and leaves the other bits unchanged. A cleared bit 31 reads 0 on the next cycle.
- R5: A write to word index 3 (offset 0xC) inverts every bit that is 1 in the data and leaves the other bits unchanged.
- R6: If bit 31 is 1 before a write, or if the write makes bit 31 equal to 1, bits 29..0 become 0 and the write data for those bits is ignored.
- R7: Clock-gate (bit 30) reads 1 in every cycle in which soft-reset read 1 three cycles earlier. Hardware sets it without any write, and a write that tries to clear it during that time has no effect.
- R8: The peripheral reset output is 1 while bit 31 is 1 and for exactly three cycles after bit 31 falls. In every other cycle it is 0.
- R9: The clock enable output is always the inverse of bit 30 as read back.
- R10: The read data always shows the current register value. Without a write it changes only through R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_word | input | 2 | Alias select: 0 load, 1 set, 2 clear, 3 toggle (byte offset = 4 × index) |
| wr_data | input | 32 | Write data or bit mask |
| rd_data | output | 32 | Current register contents |
| periph_rst | output | 1 | Active-high reset to the peripheral |
| clk_en | output | 1 | Active-high clock enable for the peripheral clock gate |

## Verification
The hardest situations to produce are writes that land inside the three-cycle settle window. Examples are a clear of clock-gate right after soft-reset falls, or a load that releases soft-reset and carries data for the lower bits. Both can only happen at exact cycle offsets from an earlier write. The bench places these writes back to back at fixed distances from the soft-reset edge. It then runs a long random mix of aliases in which bits 31 and 30 are toggled often, so that writes fall at every offset inside the window. A cycle-by-cycle history model checks each of those writes.

// File: rtl/ctl_alias_pkg.sv
package ctl_alias_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TOG  = 2'd3
  } alias_op_e;
endpackage

// File: rtl/alias_merge.sv
// Combines the current register word with the write data according to the
// selected alias. Without a write the current word passes through unchanged.
module alias_merge
  import ctl_alias_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         wr_en,
  input  logic [1:0]   wr_word,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] data,
  output logic [W-1:0] cand
);
  alias_op_e op;

  always_comb begin
    op   = alias_op_e'(wr_word);
    cand = cur;
    if (wr_en) begin
      unique case (op)
        OP_LOAD: cand = data;
        OP_SET:  cand = cur | data;
        OP_CLR:  cand = cur & ~data;
        OP_TOG:  cand = cur ^ data;
      endcase
    end
  end
endmodule

// File: rtl/srst_settle.sv
// Delay line that models how long the soft-reset request takes to settle.
// taps[i] holds the soft-reset value from i+1 cycles ago. After reset every
// tap reads 1, because soft-reset itself comes up as 1.
module srst_settle #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst_in,
  output logic [DEPTH-1:0] taps
);
  logic [DEPTH-1:0] taps_d;

  always_comb begin
    taps_d[0] = srst_in;
    for (int i = 1; i < DEPTH; i++) taps_d[i] = taps[i-1];
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) taps[g] <= 1'b1;
        else        taps[g] <= taps_d[g];
      end
    end
  endgenerate

  // R8: the first stage follows its input by exactly one cycle
  assert_first_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_in) |=> taps[0]);
endmodule

// File: rtl/ctl_alias_reg.sv
module ctl_alias_reg #(
  parameter int W      = 32,
  parameter int SETTLE = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_word,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         periph_rst,
  output logic         clk_en
);
  localparam int SRST_BIT = W - 1;
  localparam int GATE_BIT = W - 2;
  localparam int LOW_W    = W - 2;
  localparam int GATE_TAP = SETTLE - 2;
  localparam logic [W-1:0] RESET_VAL = {2'b11, {LOW_W{1'b0}}};

  logic [W-1:0]      reg_q;
  logic [W-1:0]      reg_d;
  logic [W-1:0]      cand;
  logic [SETTLE-1:0] taps;
  logic              reg_en;
  logic              gate_force;

  alias_merge #(.W(W)) u_merge (
    .wr_en  (wr_en),
    .wr_word(wr_word),
    .cur    (reg_q),
    .data   (wr_data),
    .cand   (cand)
  );

  srst_settle #(.DEPTH(SETTLE)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_in(reg_q[SRST_BIT]),
    .taps   (taps)
  );

  // next state
  always_comb begin
    gate_force = taps[GATE_TAP];
    reg_en     = wr_en | gate_force;
    reg_d      = cand;
    reg_d[GATE_BIT] = cand[GATE_BIT] | gate_force;
    if (reg_q[SRST_BIT] | cand[SRST_BIT]) reg_d[LOW_W-1:0] = '0;
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= RESET_VAL;
    else if (reg_en) reg_q <= reg_d;
  end

  assign rd_data    = reg_q;
  assign periph_rst = reg_q[SRST_BIT] | (|taps);
  assign clk_en     = ~reg_q[GATE_BIT];

  // R3: set alias always raises the control bits selected by the data
  assert_set_ctl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word == 2'd1) |=>
      ((rd_data[W-1:W-2] & $past(wr_data[W-1:W-2])) == $past(wr_data[W-1:W-2])));

  // R4: clear alias on bit 31 drops soft-reset on the next cycle
  assert_clr_srst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word == 2'd2 && wr_data[SRST_BIT]) |=> !rd_data[SRST_BIT]);

  // R6: lower bits stay zero while soft-reset is set
  assert_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[SRST_BIT] |-> (rd_data[LOW_W-1:0] == '0));

  // R7: a settled soft-reset forces clock-gate on the following cycle
  assert_gate_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
    taps[GATE_TAP] |=> rd_data[GATE_BIT]);

  // R8: reset output stays active on the cycle soft-reset falls
  assert_rst_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[SRST_BIT]) |-> periph_rst);

  // R8: reset output may only drop once soft-reset is already low
  assert_rst_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(periph_rst) |-> !rd_data[SRST_BIT]);
endmodule

// File: tb/test_ctl_alias_reg.sv
`timescale 1ns/1ps
module test_ctl_alias_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_word;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        periph_rst;
  logic        clk_en;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ctl_alias_reg i_ctl_alias_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_word   (wr_word),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .periph_rst(periph_rst),
    .clk_en    (clk_en)
  );

  // Behavioural reference: the word plus a history queue of soft-reset values
  logic [31:0] m_reg;
  bit          hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 32'hC000_0000;
      hist  = '{1'b1, 1'b1, 1'b1};
    end else begin
      logic [31:0] nxt;
      bit cur_s;
      nxt   = m_reg;
      cur_s = m_reg[31];
      if (wr_en) begin
        case (wr_word)
          2'd0: nxt = wr_data;
          2'd1: nxt = m_reg | wr_data;
          2'd2: nxt = m_reg & ~wr_data;
          default: nxt = m_reg ^ wr_data;
        endcase
      end
      if (hist[1]) nxt[30] = 1'b1;
      if (cur_s || nxt[31]) nxt[29:0] = '0;
      m_reg = nxt;
      hist.push_front(cur_s);
      while (hist.size() > 3) void'(hist.pop_back());
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_rst;
      exp_rst = m_reg[31] | hist[0] | hist[1] | hist[2];
      check("R10 readback", rd_data, m_reg);
      check("R8 periph_rst", {31'b0, periph_rst}, {31'b0, exp_rst});
      check("R9 clk_en", {31'b0, clk_en}, {31'b0, ~m_reg[30]});
    end
  end

  task automatic do_wr(logic [1:0] w, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_word = w; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_word = 2'd0; wr_data = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 reset word", rd_data, 32'hC000_0000);
    check("R1 reset periph_rst", {31'b0, periph_rst}, 32'd1);
    check("R1 reset clk_en", {31'b0, clk_en}, 32'd0);

    // release soft-reset, watch the settle window
    do_wr(2'd2, 32'h8000_0000);
    check("R4 clear srst", rd_data, 32'h4000_0000);
    check("R8 window active", {31'b0, periph_rst}, 32'd1);
    idle(3);
    check("R8 window over", {31'b0, periph_rst}, 32'd0);
    do_wr(2'd2, 32'h4000_0000);
    check("R4 clear gate", rd_data, 32'h0000_0000);
    check("R9 clock enabled", {31'b0, clk_en}, 32'd1);

    do_wr(2'd0, 32'h0000_1234);
    check("R2 load", rd_data, 32'h0000_1234);
    do_wr(2'd1, 32'h0000_0F00);
    check("R3 set", rd_data, 32'h0000_1F34);
    do_wr(2'd3, 32'h0000_00FF);
    check("R5 toggle", rd_data, 32'h0000_1FCB);
    do_wr(2'd2, 32'h000F_0000);
    check("R4 clear of zero bits", rd_data, 32'h0000_1FCB);

    // assert soft-reset: lower bits drop, gate rises after three cycles
    do_wr(2'd1, 32'h8000_0000);
    check("R6 lower cleared", rd_data, 32'h8000_0000);
    check("R8 reset immediate", {31'b0, periph_rst}, 32'd1);
    idle(2);
    check("R7 gate not yet", {31'b0, rd_data[30]}, 32'd0);
    idle(1);
    check("R7 gate by hardware", {31'b0, rd_data[30]}, 32'd1);
    check("R9 clock disabled", {31'b0, clk_en}, 32'd0);

    // load that releases soft-reset: lower data ignored, gate held
    do_wr(2'd0, 32'h0000_5555);
    check("R6 lower ignored", rd_data, 32'h4000_0000);
    do_wr(2'd2, 32'h4000_0000);
    check("R7 gate clear overridden", {31'b0, rd_data[30]}, 32'd1);
    idle(2);
    do_wr(2'd2, 32'h4000_0000);
    check("R7 gate clear after window", rd_data, 32'h0000_0000);
    check("R8 released", {31'b0, periph_rst}, 32'd0);

    // random mix of aliases with frequent control-bit traffic
    for (int i = 0; i < 600; i++) begin
      logic [31:0] d;
      d = $urandom;
      if (($urandom % 4) != 0) d[31:30] = 2'b00;
      if (($urandom % 3) == 0) idle($urandom % 4);
      do_wr(2'($urandom % 4), d);
    end
    idle(5);
    finish_run();
  end
endmodule